// File: doc/BRIEF.md
# Ethernet PHY Station-Management Master

This block lets software reach the configuration registers of external Ethernet PHY devices over the two-wire management interface (MDC clock, bidirectional MDIO data). Software sees two 32-bit registers through a simple word read/write port. The command register holds the target PHY address, the register index inside that PHY, a clock-range code, a direction flag and a busy flag. The data register holds the 16-bit value to send or the value received.

Setting the busy flag starts an access. The block derives MDC from the system clock with a divisor that the clock-range code selects. It shifts out a 64-bit management frame and, on a read, releases MDIO and collects the PHY's reply. It clears busy when the frame ends, and any register write that arrives while busy is set is dropped. MDIO leaves the block as a separate output value and output enable, so an external tri-state pad can drive it.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset both registers read 0x00000000. MDC is low and MDIO is released (`mdio_oe` = 0) at every moment an access is not in progress.
- R2: The command register is at byte offset 0x0 and the data register at 0x4. Command fields: PHY address in bits 15:11, register index in bits 10:6, clock-range code in bits 4:2, write flag in bit 1, busy in bit 0. Bit 5 and bits 31:16 read as 0. The data value is in bits 15:0 and bits 31:16 read 0. Any other offset reads 0. `bus_rdata` shows the addressed register one clock after the address is presented.
- R3: Writing the command register while idle with bit 0 = 1 stores the fields and starts an access, and busy reads 1. With bit 0 = 0 the write only stores the fields and MDC stays low.
- R4: The MDC period in system clocks is 42 for code 000, 62 for 001, 16 for 010, 26 for 011 and 102 for 100. Codes 101, 110 and 111 give 102. MDC is high for exactly half of each period.
- R5: A write access sends 32 ones, then 01, then opcode 01, then the PHY address and register index (MSB first), then turnaround 10, then the 16 data bits (MSB first). Every bit is driven with `mdio_oe` = 1.
- R6: A read access sends the same header with opcode 10. It releases MDIO for the two turnaround bits and the 16 data bits, samples `mdio_in` on each rising MDC edge of the data bits (MSB first), and places the result in the data register.
- R7: MDIO output value and enable change only when MDC falls or while MDC is low, never while MDC stays high.
- R8: Busy clears on the system clock edge after the final falling MDC edge, which is 64·D+2 clocks after the edge that accepted the starting write (D = MDC period).
- R9: While busy is 1, writes to the command register and to the data register are ignored. Neither the frame in flight nor the register contents change.
- R10: Each access produces exactly 64 rising MDC edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the addressed register |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable for the pad |
| mdio_in | input | 1 | MDIO value seen at the pad |

## Verification
On every cycle the assertions check four things. MDC and the MDIO enable are never active outside an access. The MDIO value and enable hold steady while MDC stays high. The stored command and data stay frozen while busy is set. Busy only falls right after the sequencer reports the frame end.

Some behaviours only the bench scenarios can show. These are the exact divisor for each clock-range code, including the reserved fallback, and the bit-exact content of write and read frames against a responding PHY model. They also include the cycle count until busy reads clear, the reserved-bit readback, and that a mid-frame register write leaves both the frame and the stored values untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int REG_W      = 32;
  localparam int DATA_W     = 16;
  localparam int PHY_W      = 5;
  localparam int CR_W       = 3;
  localparam int HALF_MAX   = 51;
  localparam int HALF_CNT_W = $clog2(HALF_MAX + 1);

  typedef struct packed {
    logic [PHY_W-1:0] phy;
    logic [PHY_W-1:0] regi;
    logic [CR_W-1:0]  crange;
    logic             wr;
  } mgmt_cmd_t;

  // half of the MDC period, in system clocks, for a clock-range code
  function automatic logic [HALF_CNT_W-1:0] half_period(input logic [CR_W-1:0] code);
    case (code)
      3'd0:    half_period = HALF_CNT_W'(21);
      3'd1:    half_period = HALF_CNT_W'(31);
      3'd2:    half_period = HALF_CNT_W'(8);
      3'd3:    half_period = HALF_CNT_W'(13);
      default: half_period = HALF_CNT_W'(HALF_MAX);
    endcase
  endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] half,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick     = en && (cnt_q == half - 1'b1);
  assign rise_stb = tick && !mdc_q;
  assign fall_stb = tick && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mgmt_cmd_t         cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_in,
  output logic              active,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  localparam int FRAME_W = PRE_LEN + 4 + 2 * PHY_W + 2 + DATA_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(FRAME_W - DATA_W - 2);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(FRAME_W - DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame_w;
  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   idx_nx;
  logic [DATA_W-1:0]  cap_q;
  logic               active_q, oe_q, done_q, is_wr_q;

  assign frame_w = {{PRE_LEN{1'b1}}, 2'b01,
                    cmd.wr ? 2'b01 : 2'b10,
                    cmd.phy, cmd.regi,
                    cmd.wr ? 2'b10 : 2'b11,
                    cmd.wr ? wdata : {DATA_W{1'b1}}};
  assign idx_nx  = idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      idx_q    <= '0;
      cap_q    <= '0;
      active_q <= 1'b0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      is_wr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !active_q) begin
        sh_q     <= frame_w;
        idx_q    <= '0;
        active_q <= 1'b1;
        oe_q     <= 1'b1;
        is_wr_q  <= cmd.wr;
      end else if (active_q) begin
        if (rise_stb && !is_wr_q && idx_q >= DATA_IDX)
          cap_q <= {cap_q[DATA_W-2:0], mdio_in};
        if (fall_stb) begin
          if (idx_q == LAST_IDX) begin
            sh_q     <= '0;
            active_q <= 1'b0;
            oe_q     <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            idx_q <= idx_nx;
            sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
            oe_q  <= is_wr_q || (idx_nx < TA_IDX);
          end
        end
      end
    end
  end

  assign active   = active_q;
  assign mdio_out = sh_q[FRAME_W-1];
  assign mdio_oe  = oe_q;
  assign done     = done_q;
  assign rdata    = cap_q;

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
  parameter logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_result,
  output mgmt_cmd_t         cmd,
  output logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              start
);

  mgmt_cmd_t         cmd_q;
  logic [DATA_W-1:0] data_q;
  logic [REG_W-1:0]  rdata_q;
  logic [REG_W-1:0]  ctrl_view;
  logic              busy_q, start_q;
  logic              sel_ctrl, sel_data;
  logic              unused_bits;

  assign sel_ctrl    = (bus_addr == CTRL_OFS);
  assign sel_data    = (bus_addr == DATA_OFS);
  assign ctrl_view   = {16'h0, cmd_q.phy, cmd_q.regi, 1'b0, cmd_q.crange, cmd_q.wr, busy_q};
  assign unused_bits = ^{bus_wdata[31:16], bus_wdata[5]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (busy_q) begin
        if (done) begin
          busy_q <= 1'b0;
          if (!cmd_q.wr) data_q <= rd_result;
        end
      end else if (bus_we) begin
        if (sel_ctrl) begin
          cmd_q.phy    <= bus_wdata[15:11];
          cmd_q.regi   <= bus_wdata[10:6];
          cmd_q.crange <= bus_wdata[4:2];
          cmd_q.wr     <= bus_wdata[1];
          busy_q       <= bus_wdata[0];
          start_q      <= bus_wdata[0];
        end else if (sel_data) begin
          data_q <= bus_wdata[DATA_W-1:0];
        end
      end
      if (sel_ctrl)      rdata_q <= ctrl_view;
      else if (sel_data) rdata_q <= {16'h0, data_q};
      else               rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign cmd       = cmd_q;
  assign wdata     = data_q;
  assign busy      = busy_q;
  assign start     = start_q;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
  parameter logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(4),
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);

  mgmt_cmd_t         cmd_w;
  logic [DATA_W-1:0] wdata_w;
  logic [DATA_W-1:0] rd_result_w;
  logic              busy_w, start_w, done_w, active_w;
  logic              rise_w, fall_w;

  mdio_reg_bank #(
    .ADDR_W   (ADDR_W),
    .CTRL_OFS (CTRL_OFS),
    .DATA_OFS (DATA_OFS)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done      (done_w),
    .rd_result (rd_result_w),
    .cmd       (cmd_w),
    .wdata     (wdata_w),
    .busy      (busy_w),
    .start     (start_w)
  );

  mdio_clk_gen #(
    .CNT_W (HALF_CNT_W)
  ) u_clk (
    .clk      (clk),
    .rst      (rst),
    .en       (active_w),
    .half     (half_period(cmd_w.crange)),
    .mdc      (mdc),
    .rise_stb (rise_w),
    .fall_stb (fall_w)
  );

  mdio_frame_seq #(
    .PRE_LEN (PRE_LEN)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start_w),
    .cmd      (cmd_w),
    .wdata    (wdata_w),
    .rise_stb (rise_w),
    .fall_stb (fall_w),
    .mdio_in  (mdio_in),
    .active   (active_w),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .done     (done_w),
    .rdata    (rd_result_w)
  );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        busy,
  input logic        done,
  input logic [13:0] cmd,
  input logic [15:0] data
);

  // R1
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    mdc |-> busy);

  // R1
  mdio_released_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);

  // R7
  mdio_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  // R9
  regs_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cmd) && $stable(data)));

  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done));

endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .mdc      (mdc),
  .mdio_out (mdio_out),
  .mdio_oe  (mdio_oe),
  .busy     (busy_w),
  .done     (done_w),
  .cmd      (cmd_w),
  .data     (wdata_w)
);

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {code[3], wr, phy[5], reg[5], wdata[16], reply[16], period[8]}
  localparam logic [53:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 5'h01, 5'h02, 16'hA5C3, 16'h0000, 8'd42},
    {3'd1, 1'b0, 5'h1F, 5'h1F, 16'h5555, 16'h1234, 8'd62},
    {3'd2, 1'b1, 5'h10, 5'h00, 16'hFFFF, 16'h0000, 8'd16},
    {3'd3, 1'b0, 5'h00, 5'h11, 16'h5555, 16'h8001, 8'd26},
    {3'd4, 1'b1, 5'h15, 5'h0A, 16'h0001, 16'h0000, 8'd102},
    {3'd5, 1'b0, 5'h03, 5'h1C, 16'h5555, 16'hBEEF, 8'd102},
    {3'd7, 1'b1, 5'h0E, 5'h07, 16'h8000, 16'h0000, 8'd102}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rises = 0;
  int last_rise = 0;
  int per_min, per_max, hi_min, hi_max;
  logic [63:0] cap_out, cap_oe;
  logic [15:0] reply = '0;
  logic        prev_mdc = 1'b0, prev_out = 1'b0, prev_oe = 1'b0;
  int r7_err = 0;

  mdio_mgmt_master uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst && mdc && prev_mdc && (mdio_out !== prev_out || mdio_oe !== prev_oe))
      r7_err <= r7_err + 1;
    prev_mdc <= mdc;
    prev_out <= mdio_out;
    prev_oe  <= mdio_oe;
  end

  // PHY responder and MDC timing monitor
  always @(posedge mdc) begin
    rises = rises + 1;
    cap_out = {cap_out[62:0], mdio_out};
    cap_oe  = {cap_oe[62:0], mdio_oe};
    if (rises > 1) begin
      if (cyc - last_rise < per_min) per_min = cyc - last_rise;
      if (cyc - last_rise > per_max) per_max = cyc - last_rise;
    end
    last_rise = cyc;
  end

  always @(negedge mdc) begin
    if (cyc - last_rise < hi_min) hi_min = cyc - last_rise;
    if (cyc - last_rise > hi_max) hi_max = cyc - last_rise;
    if (rises >= 48 && rises <= 63) mdio_in <= reply[63 - rises];
    else if (rises == 47)           mdio_in <= 1'b0;
    else                            mdio_in <= 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic clear_mon();
    rises = 0; per_min = 1 << 20; per_max = 0; hi_min = 1 << 20; hi_max = 0;
    cap_out = '0; cap_oe = '0;
  endtask

  // counts rdata updates until the command register shows busy = 0
  task automatic wait_idle(output int n);
    n = 0;
    bus_addr = 3'd0;
    do begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (bus_rdata[0] && n < 20000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    bus_read(3'd0, rd); chk("R1 ctrl reset", rd, 0);
    bus_read(3'd4, rd); chk("R1 data reset", rd, 0);
    chk("R1 mdc low", mdc, 0);
    chk("R1 mdio released", mdio_oe, 0);

    // R2/R3: reserved bits, no start without bit 0
    clear_mon();
    bus_write(3'd0, 32'hFFFF_FFDE);
    bus_read(3'd0, rd); chk("R2 ctrl reserved zero", rd, 32'h0000_FFDE);
    bus_write(3'd4, 32'hABCD_1234);
    bus_read(3'd4, rd); chk("R2 data upper zero", rd, 32'h0000_1234);
    bus_read(3'd2, rd); chk("R2 unmapped offset", rd, 0);
    repeat (300) @(negedge clk);
    chk("R3 no access without busy bit", rises, 0);

    // table of accesses
    for (int i = 0; i < NVEC; i++) begin
      logic [53:0] v;
      logic [2:0]  cr;
      logic        wr;
      logic [4:0]  pa, ra;
      logic [15:0] dat;
      logic [63:0] exp_out, exp_oe;
      int          dv;
      v = VEC[i];
      cr = v[53:51]; wr = v[50]; pa = v[49:45]; ra = v[44:40];
      dat = v[39:24]; reply = v[23:8]; dv = int'(v[7:0]);
      clear_mon();
      bus_write(3'd4, {16'h0, dat});
      bus_write(3'd0, {16'h0, pa, ra, 1'b0, cr, wr, 1'b1});
      wait_idle(n);
      chk("R8 busy clear latency", n, 64 * dv + 3);
      chk("R10 rising edge count", rises, 64);
      chk("R4 mdc period min", per_min, dv);
      chk("R4 mdc period max", per_max, dv);
      chk("R4 mdc high time", {hi_min[31:0], hi_max[31:0]}, {dv / 2, dv / 2});
      if (wr) begin
        exp_out = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, dat};
        exp_oe  = '1;
        chk("R5 write frame oe", cap_oe, exp_oe);
        chk("R5 write frame bits", cap_out, exp_out);
        bus_read(3'd4, rd); chk("R5 data kept", rd, {16'h0, dat});
      end else begin
        exp_out = {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 18'h0};
        exp_oe  = 64'hFFFF_FFFF_FFFC_0000;
        chk("R6 read frame oe", cap_oe, exp_oe);
        chk("R6 read header bits", cap_out & exp_oe, exp_out);
        bus_read(3'd4, rd); chk("R6 read result", rd, {16'h0, reply});
      end
      bus_read(3'd0, rd);
      chk("R2 ctrl after access", rd, {16'h0, pa, ra, 1'b0, cr, wr, 1'b0});
      chk("R1 idle mdc/oe", {mdc, mdio_oe}, 2'b00);
    end

    // R9: writes during an access are ignored
    clear_mon();
    bus_write(3'd4, 32'h0000_0F0F);
    bus_write(3'd0, {16'h0, 5'h05, 5'h09, 1'b0, 3'd2, 1'b1, 1'b1});
    repeat (100) @(negedge clk);
    bus_read(3'd0, rd); chk("R3 busy reads one", rd[0], 1);
    bus_write(3'd0, 32'h0000_FFFE);
    bus_write(3'd4, 32'h0000_1111);
    wait_idle(n);
    chk("R9 frame unchanged", cap_out, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h05, 5'h09, 2'b10, 16'h0F0F});
    bus_read(3'd0, rd); chk("R9 ctrl unchanged", rd, {16'h0, 5'h05, 5'h09, 1'b0, 3'd2, 1'b1, 1'b0});
    bus_read(3'd4, rd); chk("R9 data unchanged", rd, 32'h0000_0F0F);

    chk("R7 mdio steady while mdc high", r7_err, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule